// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block sits between an 8-bit parallel image sensor and the rest of a capture pipeline. It takes the sensor's pixel clock, line sync, frame sync and data bus as slow asynchronous inputs. It oversamples all of them in the system clock domain, finds the pixel-clock edge that carries data, and produces a one-cycle pixel strobe with the captured byte.

Configuration bits are plain inputs. They select the latch edge, optional inversion of the pixel clock and of the data lines, the line-sync polarity, and whether line sync gates pixel qualification. Optional decimation drops whole rows and columns with a keep-one-drop-N pattern. A configurable edge of frame sync marks the start of a frame. That edge sets a sticky flag, can raise an interrupt, and advances a 16-bit frame counter.

Top module: `pcap_front`

## Requirements
- R1: One pixel is captured per selected pixel-clock edge. The raw pixel clock's rising edge is used when `cfg_edge_rise` XOR `cfg_clk_inv` is 1, and its falling edge otherwise. The captured byte is the data present at that edge.
- R2: When `cfg_data_inv` is 1, every bit of the captured byte is inverted.
- R3: With `cfg_gated` = 1, a pixel is produced only while line sync is active. With `cfg_gated` = 0, the line-sync level has no effect on which pixel-clock edges produce pixels.
- R4: Line sync is active when its level equals `cfg_hs_high` (1 = active high, 0 = active low). A line starts when line sync becomes active.
- R5: With `cfg_skip_en` = 1, each kept pixel is followed by `cfg_hskip` dropped pixels. The column phase restarts at every line start, so the first pixel of a line is kept.
- R6: With `cfg_skip_en` = 1, the first line after a frame start is kept, and each kept line is followed by `cfg_vskip` dropped lines.
- R7: With `cfg_skip_en` = 0, both skip counts are ignored and every qualified pixel is output.
- R8: A frame-start event occurs on the rising edge of frame sync when `cfg_sof_rise` = 1, and on its falling edge otherwise. Each event sets `sof_flag`.
- R9: A one-cycle `sof_clr` pulse clears `sof_flag` unless a new event arrives in the same cycle. `sof_irq` equals `sof_flag` masked by `cfg_sof_irq_en`.
- R10: `frame_count` increases by exactly one on each frame-start event and wraps from 0xFFFF to 0.
- R11: A `frm_cnt_clr` pulse sets `frame_count` to zero on the next cycle, taking priority over an increment.
- R12: After reset, `pix_valid`, `sof_flag`, `sof_irq` and `frame_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_in | input | 1 | Raw sensor pixel clock |
| pdata_in | input | 8 | Raw sensor data bus |
| hsync_in | input | 1 | Raw line sync |
| vsync_in | input | 1 | Raw frame sync |
| cfg_edge_rise | input | 1 | 1 latches on the (possibly inverted) clock's rising edge, 0 on its falling edge |
| cfg_clk_inv | input | 1 | Invert the pixel clock before edge detection |
| cfg_data_inv | input | 1 | Invert all data lines |
| cfg_gated | input | 1 | Qualify pixels with line sync |
| cfg_hs_high | input | 1 | Line sync polarity, 1 = active high |
| cfg_sof_rise | input | 1 | Frame start on frame-sync rising edge when 1 |
| cfg_sof_irq_en | input | 1 | Interrupt enable for the frame-start flag |
| sof_clr | input | 1 | Write-one-to-clear pulse for the flag |
| cfg_skip_en | input | 1 | Master enable for decimation |
| cfg_hskip | input | 8 | Columns dropped after each kept column |
| cfg_vskip | input | 8 | Rows dropped after each kept row |
| frm_cnt_clr | input | 1 | Self-clearing frame counter reset request |
| pix_valid | output | 1 | One-cycle pixel strobe |
| pix_data | output | 8 | Captured pixel |
| sof_flag | output | 1 | Sticky frame-start status |
| sof_irq | output | 1 | Masked frame-start interrupt |
| frame_count | output | 16 | Frame counter |

## Verification
The sensor model changes the data bus between the rising and the falling pixel-clock edge, so each edge sees a different byte. Every combination of edge select and clock inversion therefore yields a distinct expected stream. Frames mix blanking pixels with line sync inactive and active pixels with it active, which separates gated from free-running qualification under both polarities. Decimation runs with several column and row skip values and with the master enable off while non-zero counts are set. Frame-sync pulses alternate the selected edge and check the flag between its two edges, which shows which edge raised it.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int PCAP_PIX_W       = 8;
  localparam int PCAP_SKIP_W      = 8;
  localparam int PCAP_CNT_W       = 16;
  localparam int PCAP_SYNC_STAGES = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } pcap_edge_e;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcap_qualify.sv
module pcap_qualify #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pclk_s,
  input  logic             hs_s,
  input  logic [PIX_W-1:0] d_s,
  input  logic             cfg_edge_rise,
  input  logic             cfg_clk_inv,
  input  logic             cfg_data_inv,
  input  logic             cfg_gated,
  input  logic             cfg_hs_high,
  output logic             q_valid,
  output logic [PIX_W-1:0] q_data,
  output logic             q_line_start
);
  import pcap_pkg::*;

  logic pclk_prev, hs_prev;
  logic raw_rise, raw_fall, cap_edge;
  logic hs_act, hs_act_prev;
  pcap_edge_e raw_sel;

  // Edges come from the raw samples and are remapped, so a change of the
  // inversion or polarity settings never looks like an edge.
  assign raw_rise    = pclk_s & ~pclk_prev;
  assign raw_fall    = ~pclk_s & pclk_prev;
  assign raw_sel     = pcap_edge_e'(cfg_edge_rise ^ cfg_clk_inv);
  assign cap_edge    = (raw_sel == EDGE_RISE) ? raw_rise : raw_fall;
  assign hs_act      = ~(hs_s ^ cfg_hs_high);
  assign hs_act_prev = ~(hs_prev ^ cfg_hs_high);

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_prev    <= 1'b0;
      hs_prev      <= 1'b0;
      q_valid      <= 1'b0;
      q_data       <= '0;
      q_line_start <= 1'b0;
    end else begin
      pclk_prev    <= pclk_s;
      hs_prev      <= hs_s;
      q_valid      <= cap_edge & (~cfg_gated | hs_act);
      q_line_start <= hs_act & ~hs_act_prev;
      if (cap_edge) q_data <= d_s ^ {PIX_W{cfg_data_inv}};
    end
  end

  AST_GATED_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (cfg_gated && !hs_act) |=> !q_valid); // R3
  AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> !q_valid); // R1
  AST_LINE_PULSE: assert property (@(posedge clk) disable iff (rst)
    q_line_start |=> !q_line_start); // R4
endmodule

// File: rtl/pcap_decimate.sv
module pcap_decimate #(
  parameter int PIX_W  = 8,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_data,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              cfg_skip_en,
  input  logic [SKIP_W-1:0] cfg_hskip,
  input  logic [SKIP_W-1:0] cfg_vskip,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data
);
  logic [SKIP_W-1:0] col_cnt, row_cnt;
  logic [SKIP_W-1:0] col_base, row_base;
  logic              row_keep, row_keep_now, col_keep;

  function automatic logic [SKIP_W-1:0] phase_step(input logic [SKIP_W-1:0] c,
                                                   input logic [SKIP_W-1:0] lim);
    return (c >= lim) ? '0 : c + 1'b1;
  endfunction

  assign col_base     = line_start ? '0 : col_cnt;
  assign col_keep     = (col_base == '0);
  assign row_base     = frame_start ? '0 : row_cnt;
  assign row_keep_now = line_start ? (row_base == '0) : (frame_start | row_keep);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_cnt   <= '0;
      row_cnt   <= '0;
      row_keep  <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_valid)        col_cnt <= phase_step(col_base, cfg_hskip);
      else if (line_start) col_cnt <= '0;

      row_keep <= row_keep_now;
      if (line_start)       row_cnt <= phase_step(row_base, cfg_vskip);
      else if (frame_start) row_cnt <= '0;

      out_valid <= in_valid & (~cfg_skip_en | (col_keep & row_keep_now));
      if (in_valid) out_data <= in_data;
    end
  end

  AST_PASS_ALL: assert property (@(posedge clk) disable iff (rst)
    (!cfg_skip_en && in_valid) |=> (out_valid && out_data == $past(in_data))); // R7
  AST_NO_INVENT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R5
  AST_LINE_HEAD: assert property (@(posedge clk) disable iff (rst)
    (line_start && in_valid && !frame_start && row_cnt == '0) |=> out_valid); // R6
endmodule

// File: rtl/pcap_frame.sv
module pcap_frame #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vs_s,
  input  logic             cfg_sof_rise,
  input  logic             cfg_sof_irq_en,
  input  logic             sof_clr,
  input  logic             frm_cnt_clr,
  output logic             sof_pulse,
  output logic             sof_flag,
  output logic             sof_irq,
  output logic [CNT_W-1:0] frame_count
);
  logic vs_prev, sof_ev, flag_nxt;

  assign sof_ev   = cfg_sof_rise ? (vs_s & ~vs_prev) : (~vs_s & vs_prev);
  assign flag_nxt = sof_ev | (sof_flag & ~sof_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_prev     <= 1'b0;
      sof_pulse   <= 1'b0;
      sof_flag    <= 1'b0;
      sof_irq     <= 1'b0;
      frame_count <= '0;
    end else begin
      vs_prev   <= vs_s;
      sof_pulse <= sof_ev;
      sof_flag  <= flag_nxt;
      sof_irq   <= flag_nxt & cfg_sof_irq_en;
      if (frm_cnt_clr) frame_count <= '0;
      else if (sof_ev) frame_count <= frame_count + 1'b1;
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    frm_cnt_clr |=> (frame_count == '0)); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frm_cnt_clr && !sof_ev) |=> $stable(frame_count)); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sof_clr && !sof_ev) |=> !sof_flag); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !cfg_sof_irq_en |=> !sof_irq); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    sof_ev |=> sof_flag); // R8
endmodule

// File: rtl/pcap_front.sv
module pcap_front #(
  parameter int PIX_W       = pcap_pkg::PCAP_PIX_W,
  parameter int SKIP_W      = pcap_pkg::PCAP_SKIP_W,
  parameter int CNT_W       = pcap_pkg::PCAP_CNT_W,
  parameter int SYNC_STAGES = pcap_pkg::PCAP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_in,
  input  logic [PIX_W-1:0]  pdata_in,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              cfg_edge_rise,
  input  logic              cfg_clk_inv,
  input  logic              cfg_data_inv,
  input  logic              cfg_gated,
  input  logic              cfg_hs_high,
  input  logic              cfg_sof_rise,
  input  logic              cfg_sof_irq_en,
  input  logic              sof_clr,
  input  logic              cfg_skip_en,
  input  logic [SKIP_W-1:0] cfg_hskip,
  input  logic [SKIP_W-1:0] cfg_vskip,
  input  logic              frm_cnt_clr,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              sof_flag,
  output logic              sof_irq,
  output logic [CNT_W-1:0]  frame_count
);
  localparam int RAW_W = PIX_W + 3;

  logic [RAW_W-1:0] raw_s;
  logic             q_valid, q_line_start, sof_pulse;
  logic [PIX_W-1:0] q_data;

  // Data is synchronised alongside the strobes so both reach edge detection together.
  pcap_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({pclk_in, hsync_in, vsync_in, pdata_in}),
    .q   (raw_s)
  );

  pcap_qualify #(.PIX_W(PIX_W)) qual_i (
    .clk           (clk),
    .rst           (rst),
    .pclk_s        (raw_s[RAW_W-1]),
    .hs_s          (raw_s[RAW_W-2]),
    .d_s           (raw_s[PIX_W-1:0]),
    .cfg_edge_rise (cfg_edge_rise),
    .cfg_clk_inv   (cfg_clk_inv),
    .cfg_data_inv  (cfg_data_inv),
    .cfg_gated     (cfg_gated),
    .cfg_hs_high   (cfg_hs_high),
    .q_valid       (q_valid),
    .q_data        (q_data),
    .q_line_start  (q_line_start)
  );

  pcap_frame #(.CNT_W(CNT_W)) frame_i (
    .clk            (clk),
    .rst            (rst),
    .vs_s           (raw_s[RAW_W-3]),
    .cfg_sof_rise   (cfg_sof_rise),
    .cfg_sof_irq_en (cfg_sof_irq_en),
    .sof_clr        (sof_clr),
    .frm_cnt_clr    (frm_cnt_clr),
    .sof_pulse      (sof_pulse),
    .sof_flag       (sof_flag),
    .sof_irq        (sof_irq),
    .frame_count    (frame_count)
  );

  pcap_decimate #(.PIX_W(PIX_W), .SKIP_W(SKIP_W)) dec_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (q_valid),
    .in_data     (q_data),
    .line_start  (q_line_start),
    .frame_start (sof_pulse),
    .cfg_skip_en (cfg_skip_en),
    .cfg_hskip   (cfg_hskip),
    .cfg_vskip   (cfg_vskip),
    .out_valid   (pix_valid),
    .out_data    (pix_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pix_valid && !sof_flag && !sof_irq && frame_count == '0)); // R12
endmodule

// File: tb/pcap_front_tb_top.sv
module pcap_front_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pclk_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic [7:0] pdata_in = '0;
  logic cfg_edge_rise = 1'b1, cfg_clk_inv = 1'b0, cfg_data_inv = 1'b0;
  logic cfg_gated = 1'b1, cfg_hs_high = 1'b1, cfg_sof_rise = 1'b1;
  logic cfg_sof_irq_en = 1'b0, sof_clr = 1'b0, cfg_skip_en = 1'b0;
  logic [7:0] cfg_hskip = '0, cfg_vskip = '0;
  logic frm_cnt_clr = 1'b0;
  logic pix_valid, sof_flag, sof_irq;
  logic [7:0] pix_data;
  logic [15:0] frame_count;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] expq[$];
  logic [7:0] obsq[$];
  int m_col = 0, m_row = 0;
  bit m_rowkeep = 1'b1, hs_on = 1'b0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  pcap_front dut_i (
    .clk(clk), .rst(rst), .pclk_in(pclk_in), .pdata_in(pdata_in),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .cfg_edge_rise(cfg_edge_rise), .cfg_clk_inv(cfg_clk_inv),
    .cfg_data_inv(cfg_data_inv), .cfg_gated(cfg_gated),
    .cfg_hs_high(cfg_hs_high), .cfg_sof_rise(cfg_sof_rise),
    .cfg_sof_irq_en(cfg_sof_irq_en), .sof_clr(sof_clr),
    .cfg_skip_en(cfg_skip_en), .cfg_hskip(cfg_hskip), .cfg_vskip(cfg_vskip),
    .frm_cnt_clr(frm_cnt_clr), .pix_valid(pix_valid), .pix_data(pix_data),
    .sof_flag(sof_flag), .sof_irq(sof_irq), .frame_count(frame_count)
  );

  always @(negedge clk) if (!rst && pix_valid) obsq.push_back(pix_data);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model of decimation (R5, R6, R7)
  task automatic m_line();
    m_rowkeep = (m_row == 0);
    m_row = (m_row >= int'(cfg_vskip)) ? 0 : m_row + 1;
    m_col = 0;
  endtask

  task automatic m_pix(input logic [7:0] v);
    bit keep;
    if (cfg_gated && !hs_on) return;
    keep = !cfg_skip_en || (m_col == 0 && m_rowkeep);
    m_col = (m_col >= int'(cfg_hskip)) ? 0 : m_col + 1;
    if (keep) expq.push_back(v);
  endtask

  task automatic set_hs(input bit act);
    hsync_in = act ? cfg_hs_high : ~cfg_hs_high;
    if (act && !hs_on) m_line();
    hs_on = act;
    tick(3);
  endtask

  // Different bytes at the rising and falling raw edge (R1, R2)
  task automatic send_pix();
    logic [7:0] a, b, v;
    a = 8'($urandom);
    b = 8'($urandom);
    pdata_in = a; tick(2);
    pclk_in = 1'b1; tick(2);
    pdata_in = b; tick(2);
    pclk_in = 1'b0; tick(2);
    v = (cfg_edge_rise ^ cfg_clk_inv) ? a : b;
    if (cfg_data_inv) v = ~v;
    m_pix(v);
  endtask

  task automatic frame_start();
    sof_clr = 1'b1; tick(1); sof_clr = 1'b0; tick(1);
    check(sof_flag == 1'b0, "R9 flag clear", sof_flag, 0);
    vsync_in = 1'b1; tick(6);
    check(sof_flag == cfg_sof_rise, "R8 edge select", sof_flag, cfg_sof_rise);
    check(sof_irq == (sof_flag & cfg_sof_irq_en), "R9 irq mask", sof_irq, sof_flag & cfg_sof_irq_en);
    vsync_in = 1'b0; tick(6);
    exp_cnt = (exp_cnt + 1) & 16'hFFFF;
    check(sof_flag == 1'b1, "R8 flag set", sof_flag, 1);
    check(frame_count == 16'(exp_cnt), "R10 count step", frame_count, exp_cnt);
    m_row = 0;
    m_rowkeep = 1'b1;
  endtask

  task automatic run_frame(input string tag, input int lines, input int nact, input int nblank);
    frame_start();
    for (int l = 0; l < lines; l++) begin
      set_hs(1'b0);
      for (int p = 0; p < nblank; p++) send_pix();
      set_hs(1'b1);
      for (int p = 0; p < nact; p++) send_pix();
      set_hs(1'b0);
    end
    tick(8);
    check(obsq.size() == expq.size(), {tag, " pixel count"}, obsq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < obsq.size(); i++)
      check(obsq[i] == expq[i], {tag, " pixel value"}, obsq[i], expq[i]);
    obsq.delete();
    expq.delete();
  endtask

  task automatic set_cfg(input bit er, input bit ci, input bit di, input bit g, input bit hh,
                         input bit se, input int hk, input int vk);
    cfg_edge_rise = er; cfg_clk_inv = ci; cfg_data_inv = di; cfg_gated = g;
    cfg_hs_high = hh; cfg_skip_en = se; cfg_hskip = 8'(hk); cfg_vskip = 8'(vk);
    hsync_in = ~hh;
    hs_on = 1'b0;
    cfg_sof_rise = ~cfg_sof_rise;
    cfg_sof_irq_en = 1'($urandom);
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(5);
    rst = 1'b0;
    tick(1);
    // R12: reset state
    check(pix_valid == 1'b0, "R12 pix_valid", pix_valid, 0);
    check(sof_flag == 1'b0, "R12 sof_flag", sof_flag, 0);
    check(sof_irq == 1'b0, "R12 sof_irq", sof_irq, 0);
    check(frame_count == 16'h0, "R12 frame_count", frame_count, 0);

    set_cfg(1, 0, 0, 1, 1, 0, 0, 0); run_frame("R1 rise", 3, 6, 2);
    set_cfg(0, 0, 0, 1, 1, 0, 0, 0); run_frame("R1 fall", 3, 6, 2);
    set_cfg(1, 1, 0, 1, 1, 0, 0, 0); run_frame("R1 clk inv", 3, 6, 2);
    set_cfg(0, 1, 0, 1, 1, 0, 0, 0); run_frame("R1 clk inv fall", 3, 6, 2);
    set_cfg(1, 0, 1, 1, 1, 0, 0, 0); run_frame("R2 data inv", 3, 6, 2);
    set_cfg(1, 0, 0, 0, 1, 0, 0, 0); run_frame("R3 non-gated", 3, 6, 3);
    set_cfg(0, 0, 0, 1, 1, 0, 0, 0); run_frame("R3 gated", 3, 6, 3);
    set_cfg(1, 0, 0, 1, 0, 0, 0, 0); run_frame("R4 active low", 3, 6, 3);
    set_cfg(1, 0, 0, 1, 1, 1, 2, 0); run_frame("R5 col skip", 3, 8, 2);
    set_cfg(0, 0, 0, 1, 1, 1, 1, 2); run_frame("R6 row skip", 7, 5, 1);
    set_cfg(1, 0, 0, 1, 1, 0, 3, 3); run_frame("R7 skip off", 4, 6, 1);

    // R11: counter clear request
    frm_cnt_clr = 1'b1; tick(1); frm_cnt_clr = 1'b0; tick(1);
    exp_cnt = 0;
    check(frame_count == 16'h0, "R11 clear", frame_count, 0);

    for (int f = 0; f < 12; f++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), int'($urandom % 4), int'($urandom % 3));
      run_frame(cfg_skip_en ? "R5 R6 random" : "R1 R3 random",
                2 + int'($urandom % 4), 3 + int'($urandom % 6), int'($urandom % 3));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule